// File: doc/BRIEF.md
# Vector Byte Table Lookup Unit

This block is the permute engine of a SIMD datapath. It owns a file of 32 vector registers, each 128 bits wide. A decoded command names a destination register, a first table register, an index register, a table length, a result width and an out-of-range mode. The engine joins one to four consecutive registers into a byte table and reads each byte of the index register as an unsigned position in that table. It writes the gathered vector to the destination.

A lane whose index points beyond the table is out of range. In zeroing mode it produces zero. In keep mode it holds the byte the destination already contains. Every command takes the same fixed latency whatever the index values. A side port lets the surrounding logic load registers and read them back.

Top module: `vtbl_unit`

## Requirements
- R1: A side write (`ext_we`, `ext_waddr`, `ext_wdata`) updates the addressed register at the clock edge. `ext_rdata` shows register `ext_raddr` combinationally. Register byte j occupies bits [8j+7:8j].
- R2: `cmd_ready` is high while no command is pending. A command is accepted at an edge where `cmd_valid` and `cmd_ready` are both high. In the following cycle `done` is high for exactly one cycle and `cmd_ready` is low. The result is written at the end of that cycle, and `cmd_ready` is high again afterwards.
- R3: The table uses `cmd_len + 1` registers. Table register t is register number (`cmd_base` + t) modulo 32, so base 30 with four registers uses 30, 31, 0, 1.
- R4: Table byte k is byte (k mod 16) of table register k/16. The first table register therefore supplies table bytes 0 to 15.
- R5: Result lane i takes as its index byte i of register `cmd_idx`, read as an unsigned 8-bit value.
- R6: A lane is in range when its index is less than 16 × (`cmd_len` + 1), and it then receives that table byte. Any larger index is out of range.
- R7: With `cmd_keep` = 0, an out-of-range lane writes 0x00.
- R8: With `cmd_keep` = 1, an out-of-range lane writes the byte the destination held before the command.
- R9: With `cmd_wide` = 0, only lanes 0 to 7 are produced, and bits [127:64] of the destination are written as zero in both modes. With `cmd_wide` = 1, all 16 lanes are produced.
- R10: All sources are read before the destination is written. A destination equal to a table or index register therefore uses the old contents.
- R11: After reset, `cmd_ready` is 1 and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_dst | input | 5 | Destination register |
| cmd_base | input | 5 | First table register |
| cmd_idx | input | 5 | Index register |
| cmd_len | input | 2 | Table register count minus one |
| cmd_wide | input | 1 | 1: 16 lanes, 0: 8 lanes |
| cmd_keep | input | 1 | 1: out-of-range lanes keep old byte, 0: zero |
| done | output | 1 | Result written at the end of this cycle |
| ext_we | input | 1 | Side write enable |
| ext_waddr | input | 5 | Side write register |
| ext_wdata | input | 128 | Side write data |
| ext_raddr | input | 5 | Side read register |
| ext_rdata | output | 128 | Side read data |

## Verification
The lookup is tried with several index patterns. Ascending in-range indexes check the byte order within one register. Indexes straddling 16, 32 and 48 separate one table register from the next and find an off-by-one in the bound. Indexes of 64 and 0xFF check clamping at the largest table. A table starting at register 30 shows whether the register number wraps. The same out-of-range pattern is run in both modes and at both widths, which separates zeroing from keeping and checks the cleared upper half. Commands whose destination equals the first table register or the index register show whether sources are read before the write.

// File: rtl/vtbl_pkg.sv
package vtbl_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic {
    OOR_ZERO = 1'b0,
    OOR_KEEP = 1'b1
  } oor_mode_e;
endpackage

// File: rtl/vtbl_regfile.sv
module vtbl_regfile #(
  parameter int unsigned NREG = 32,
  parameter int unsigned VW   = 128,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     eng_we,
  input  logic [AW-1:0]            eng_waddr,
  input  logic [VW-1:0]            eng_wdata,
  input  logic                     side_we,
  input  logic [AW-1:0]            side_waddr,
  input  logic [VW-1:0]            side_wdata,
  output logic [NREG-1:0][VW-1:0]  regs_o
);
  for (genvar r = 0; r < NREG; r++) begin : g_ent
    localparam logic [AW-1:0] RID = AW'(r);
    logic          en;
    logic [VW-1:0] d;

    // engine write has priority over a side write to the same entry
    always_comb begin
      en = 1'b0;
      d  = side_wdata;
      if (eng_we && eng_waddr == RID) begin
        en = 1'b1;
        d  = eng_wdata;
      end else if (side_we && side_waddr == RID) begin
        en = 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (en) regs_o[r] <= d;
    end
  end
endmodule

// File: rtl/vtbl_gather.sv
module vtbl_gather #(
  parameter int unsigned NREG   = 32,
  parameter int unsigned VW     = 128,
  parameter int unsigned MAXTAB = 4,
  localparam int unsigned AW    = $clog2(NREG)
) (
  input  logic [NREG-1:0][VW-1:0] regs_i,
  input  logic [AW-1:0]           base_i,
  output logic [MAXTAB*VW-1:0]    table_o
);
  for (genvar t = 0; t < MAXTAB; t++) begin : g_slot
    localparam logic [AW-1:0] OFF = AW'(t);
    logic [AW-1:0] rnum;
    assign rnum = base_i + OFF;   // wraps modulo NREG
    assign table_o[t*VW +: VW] = regs_i[rnum];
  end
endmodule

// File: rtl/vtbl_lane.sv
module vtbl_lane
  import vtbl_pkg::*;
#(
  parameter int unsigned VW      = 128,
  parameter int unsigned MAXTAB  = 4,
  localparam int unsigned VBYTES = VW / BYTE_W,
  localparam int unsigned TBYTES = MAXTAB * VBYTES,
  localparam int unsigned TW     = $clog2(TBYTES),
  localparam int unsigned LW     = $clog2(MAXTAB)
) (
  input  logic [MAXTAB*VW-1:0] table_i,
  input  logic [BYTE_W-1:0]    idx_i,
  input  logic [LW-1:0]        len_i,
  input  oor_mode_e            mode_i,
  input  logic [BYTE_W-1:0]    old_i,
  input  logic                 en_i,
  output logic [BYTE_W-1:0]    byte_o
);
  logic [BYTE_W:0]   limit;
  logic              in_rng;
  logic [TW-1:0]     sel;
  logic [BYTE_W-1:0] picked;

  always_comb begin
    limit  = (BYTE_W+1)'((32'(len_i) + 32'd1) * VBYTES);
    in_rng = {1'b0, idx_i} < limit;
    sel    = idx_i[TW-1:0];
    picked = table_i[32'(sel)*BYTE_W +: BYTE_W];
    if (!en_i)                  byte_o = '0;
    else if (in_rng)            byte_o = picked;
    else if (mode_i == OOR_KEEP) byte_o = old_i;
    else                        byte_o = '0;
  end
endmodule

// File: rtl/vtbl_unit.sv
module vtbl_unit
  import vtbl_pkg::*;
#(
  parameter int unsigned NREG    = 32,
  parameter int unsigned VW      = 128,
  parameter int unsigned MAXTAB  = 4,
  localparam int unsigned AW     = $clog2(NREG),
  localparam int unsigned LW     = $clog2(MAXTAB),
  localparam int unsigned VBYTES = VW / BYTE_W,
  localparam int unsigned HALF   = VBYTES / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [AW-1:0] cmd_dst,
  input  logic [AW-1:0] cmd_base,
  input  logic [AW-1:0] cmd_idx,
  input  logic [LW-1:0] cmd_len,
  input  logic          cmd_wide,
  input  logic          cmd_keep,
  output logic          done,
  input  logic          ext_we,
  input  logic [AW-1:0] ext_waddr,
  input  logic [VW-1:0] ext_wdata,
  input  logic [AW-1:0] ext_raddr,
  output logic [VW-1:0] ext_rdata
);
  logic                    pend_q, pend_d, accept;
  logic [AW-1:0]           dst_q, base_q, idx_q;
  logic [LW-1:0]           len_q;
  logic                    wide_q;
  oor_mode_e               mode_q;
  logic [NREG-1:0][VW-1:0] regs;
  logic [MAXTAB*VW-1:0]    tab;
  logic [VW-1:0]           idx_vec, old_vec, res_w;

  always_comb begin
    accept = cmd_valid && !pend_q;
    pend_d = accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      dst_q  <= cmd_dst;
      base_q <= cmd_base;
      idx_q  <= cmd_idx;
      len_q  <= cmd_len;
      wide_q <= cmd_wide;
      mode_q <= oor_mode_e'(cmd_keep);
    end
  end

  vtbl_regfile #(.NREG(NREG), .VW(VW)) u_rf (
    .clk       (clk),
    .eng_we    (pend_q),
    .eng_waddr (dst_q),
    .eng_wdata (res_w),
    .side_we   (ext_we),
    .side_waddr(ext_waddr),
    .side_wdata(ext_wdata),
    .regs_o    (regs)
  );

  vtbl_gather #(.NREG(NREG), .VW(VW), .MAXTAB(MAXTAB)) u_gather (
    .regs_i (regs),
    .base_i (base_q),
    .table_o(tab)
  );

  assign idx_vec = regs[idx_q];
  assign old_vec = regs[dst_q];

  for (genvar l = 0; l < VBYTES; l++) begin : g_lane
    logic lane_en;
    assign lane_en = wide_q || (l < HALF);
    vtbl_lane #(.VW(VW), .MAXTAB(MAXTAB)) u_lane (
      .table_i(tab),
      .idx_i  (idx_vec[l*BYTE_W +: BYTE_W]),
      .len_i  (len_q),
      .mode_i (mode_q),
      .old_i  (old_vec[l*BYTE_W +: BYTE_W]),
      .en_i   (lane_en),
      .byte_o (res_w[l*BYTE_W +: BYTE_W])
    );
  end

  assign cmd_ready = !pend_q;
  assign done      = pend_q;
  assign ext_rdata = regs[ext_raddr];
endmodule

// File: rtl/vtbl_unit_chk.sv
module vtbl_unit_chk #(
  parameter int unsigned VW = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          done,
  input logic          wr_wide,
  input logic [VW-1:0] wr_data
);
  AST_ACCEPT_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> done); // R2
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_ready); // R2
  AST_DONE_IS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_READY_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> cmd_ready); // R2
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done && !wr_wide |-> wr_data[VW-1:VW/2] == '0); // R9
endmodule

bind vtbl_unit vtbl_unit_chk #(.VW(VW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready),
  .done     (done),
  .wr_wide  (wide_q),
  .wr_data  (res_w)
);

// File: tb/vtbl_unit_test.sv
`timescale 1ns/1ps
module vtbl_unit_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic [4:0]   cmd_dst = '0, cmd_base = '0, cmd_idx = '0;
  logic [1:0]   cmd_len = '0;
  logic         cmd_wide = 1'b0, cmd_keep = 1'b0;
  logic         done;
  logic         ext_we = 1'b0;
  logic [4:0]   ext_waddr = '0, ext_raddr = '0;
  logic [127:0] ext_wdata = '0;
  logic [127:0] ext_rdata;

  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;
  logic [127:0] shadow [32];

  always #2 clk = ~clk;

  vtbl_unit uut (.*);

  // fields: dst[146:142] base[141:137] idx[136:132] len[131:130] wide[129] keep[128] data[127:0]
  localparam int NV = 9;
  localparam logic [146:0] VECS [NV] = '{
    {5'd1,  5'd2,  5'd3,  2'd0, 1'b1, 1'b0, 128'h000102030405060708090a0b0c0d0e0f}, // R4 R5
    {5'd4,  5'd5,  5'd6,  2'd1, 1'b1, 1'b0, 128'h0f1e01fe40201f10001122330a211f10}, // R6 R7
    {5'd4,  5'd5,  5'd6,  2'd1, 1'b1, 1'b1, 128'h0f1e01fe40201f10001122330a211f10}, // R6 R8
    {5'd7,  5'd9,  5'd8,  2'd2, 1'b1, 1'b0, 128'h2f302e31ff10202f3000010f1f2d3233}, // R6 R7
    {5'd10, 5'd30, 5'd11, 2'd3, 1'b1, 1'b0, 128'h050111213100ff401f2f3e302010003f}, // R3
    {5'd16, 5'd8,  5'd17, 2'd3, 1'b0, 1'b0, 128'h3f3f3f3f3f3f3f3f40ff3f20100a0100}, // R9 R7
    {5'd16, 5'd8,  5'd17, 2'd0, 1'b0, 1'b1, 128'h0102030405060708ff0f10203f000111}, // R9 R8
    {5'd12, 5'd12, 5'd13, 2'd1, 1'b1, 1'b1, 128'h1f1e1d1c000102030405ff40201f1011}, // R10
    {5'd14, 5'd15, 5'd14, 2'd0, 1'b1, 1'b0, 128'h000f0e0d0c0b0a0908070605040302f1}  // R10
  };

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic side_write(logic [4:0] a, logic [127:0] v);
    @(negedge clk);
    ext_we = 1'b1; ext_waddr = a; ext_wdata = v;
    @(negedge clk);
    ext_we = 1'b0;
    shadow[a] = v;
  endtask

  function automatic logic [127:0] model(logic [4:0] d, logic [4:0] b, logic [4:0] x,
                                         logic [1:0] len, logic wide, logic keep);
    logic [511:0] tab;
    logic [127:0] iv, old, res;
    res = '0;
    for (int t = 0; t < 4; t++) tab[t*128 +: 128] = shadow[5'(b + 5'(t))];
    iv = shadow[x];
    old = shadow[d];
    for (int l = 0; l < (wide ? 16 : 8); l++) begin
      int k;
      k = int'(iv[l*8 +: 8]);
      if (k < 16 * (int'(len) + 1)) res[l*8 +: 8] = tab[k*8 +: 8];
      else if (keep) res[l*8 +: 8] = old[l*8 +: 8];
    end
    return res;
  endfunction

  task automatic run_cmd(logic [4:0] d, logic [4:0] b, logic [4:0] x,
                         logic [1:0] len, logic wide, logic keep, string tag);
    logic [127:0] exp;
    exp = model(d, b, x, len, wide, keep);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_dst = d; cmd_base = b; cmd_idx = x;
    cmd_len = len; cmd_wide = wide; cmd_keep = keep;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R2 done/ready during write cycle", {126'b0, done, cmd_ready}, 128'b10);
    @(negedge clk);
    check("R2 done/ready after write", {126'b0, done, cmd_ready}, 128'b01);
    ext_raddr = d;
    #0.5;
    check(tag, ext_rdata, exp);
    shadow[d] = exp;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset state ready/done", {126'b0, done, cmd_ready}, 128'b01);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 idle after reset release", {126'b0, done, cmd_ready}, 128'b01);

    for (int r = 0; r < 32; r++) begin
      logic [127:0] v;
      for (int j = 0; j < 16; j++) v[j*8 +: 8] = 8'(r * 37 + j * 11 + 3);
      side_write(5'(r), v);
    end
    ext_raddr = 5'd21;
    #0.5;
    check("R1 side write readback", ext_rdata, shadow[21]);

    for (int i = 0; i < NV; i++) begin
      logic [146:0] v;
      v = VECS[i];
      side_write(v[136:132], v[127:0]);
      run_cmd(v[146:142], v[141:137], v[136:132], v[131:130], v[129], v[128],
              $sformatf("R3-R10 vector %0d result", i));
    end

    // R7 boundary: every lane exactly at the 64-byte limit, zero mode
    side_write(5'd20, {16{8'd64}});
    run_cmd(5'd19, 5'd0, 5'd20, 2'd3, 1'b1, 1'b0, "R7 all lanes index 64 zeroed");
    // R8 keep mode with all lanes out of range leaves destination unchanged
    run_cmd(5'd19, 5'd0, 5'd20, 2'd3, 1'b1, 1'b1, "R8 all lanes out of range keep");
    // R6 last valid byte of a one-register table
    side_write(5'd20, {16{8'd15}});
    run_cmd(5'd22, 5'd23, 5'd20, 2'd0, 1'b1, 1'b0, "R6 index 15 with one register");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule